// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This receiver turns a stereo serial PCM stream into parallel 18-bit two's-complement samples, one register per channel. It runs on a fast internal system clock. The bit clock, the word-select clock and the serial data line are treated as asynchronous inputs. Each one passes through a synchronizer, and all edge detection happens in the system-clock domain. Data is taken on every rising edge of the bit clock. A transition of word select ends a channel slot.

A static format input selects the framing. In right-justified mode the word is aligned to its end: the final 18 bits before a word-select transition are the sample, and any earlier bits are discarded. In I2S mode the word is aligned to its start: the bit that directly follows the word-select edge is skipped, the next 18 bits form the sample, and later bits are ignored. When a slot closes, the receiver either loads the matching channel register and pulses that channel's strobe for one cycle, or, if the slot was too short, pulses an incomplete-frame flag.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held, and right after it is released, both sample outputs read 0 and `left_valid`, `right_valid` and `frame_err` are low.
- R2: With `fmt_i2s` low, the last 18 bits captured before a word-select transition form the sample, MSB first, bit-exact including negative values. A slot with word select high is the left channel. A slot with word select low is the right channel.
- R3: In right-justified mode, bit clocks in a slot beyond the final 18 are discarded and do not change the sample.
- R4: With `fmt_i2s` high, a slot with word select low is the left channel. The first bit after the word-select edge is skipped. The following 18 bits are the sample, MSB first. Any bits after those 18 in the same slot are ignored.
- R5: A channel's strobe is high for exactly one system-clock cycle, after the word-select transition that closes that channel's slot.
- R6: Each sample output holds its value between that channel's strobes.
- R7: A slot that closes with fewer than 18 rising bit-clock edges in right-justified mode, or fewer than 19 in I2S mode, pulses `frame_err` for one cycle. It raises no strobe, and both sample outputs stay unchanged.
- R8: The first word-select transition after reset only opens a slot. It produces no strobe and no `frame_err`.
- R9: Serial data is sampled only at the rising edge of the bit clock. A change on the data line while the bit clock is high has no effect.
- R10: In any cycle, at most one of `left_valid`, `right_valid` and `frame_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| wsel_in | input | 1 | Word-select clock at the sample rate, asynchronous |
| sdata_in | input | 1 | Serial audio data, MSB first |
| fmt_i2s | input | 1 | Framing select: 0 right-justified, 1 I2S; static outside reset |
| left_word | output | 18 | Last left sample, two's complement |
| left_valid | output | 1 | One-cycle strobe when `left_word` is loaded |
| right_word | output | 18 | Last right sample, two's complement |
| right_valid | output | 1 | One-cycle strobe when `right_word` is loaded |
| frame_err | output | 1 | One-cycle pulse when a slot closes incomplete |

## Verification
The embedded assertions check four things on every cycle: that the three output pulses are mutually exclusive, that each strobe lasts a single cycle, that each sample register stays still between strobes and across an incomplete-frame pulse, and that the slot bit counter stays bounded. They cannot show that the correct bits land in the correct channel. The bench scenarios cover that: the two framings with their opposite channel polarities, discarded leading bits, the skipped I2S delay bit and the ignored trailing bits, glitches during the high phase, slot lengths right at the 18/19-bit boundary, and the silent priming edge after reset.

// File: rtl/sarx_pkg.sv
// Package for the serial audio receiver.
// Holds the line indices of the synchronizer bundle, the channel type, and
// the rule that maps a word-select edge to the channel slot it closes.
package sarx_pkg;

    localparam int SARX_LINE_BCLK  = 0;
    localparam int SARX_LINE_WS    = 1;
    localparam int SARX_LINE_DATA  = 2;
    localparam int SARX_NUM_LINES  = 3;
    localparam int SARX_NUM_CH     = 2;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } sarx_chan_e;

    // Right-justified: the slot with word select high is left, so a falling edge closes left.
    // I2S: the slot with word select low is left, so a rising edge closes left.
    function automatic sarx_chan_e sarx_closing_chan(input logic fmt_i2s, input logic ws_new);
        return (ws_new == fmt_i2s) ? CH_LEFT : CH_RIGHT;
    endfunction

endpackage

// File: rtl/sarx_sync.sv
// Multi-line synchronizer.
// Passes each asynchronous line through STAGES flip-flops clocked by clk.
// Assumes every line is slow compared with clk: each level lasts at least
// two clk periods, so edge detection after this block misses no edge.
// All lines have the same latency, so data keeps its alignment with the bit clock.
module sarx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    generate
        for (genvar li = 0; li < WIDTH; li++) begin : g_line
            logic [STAGES-1:0] chain;

            // Shift the raw level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_i[li]};
            end

            assign sync_o[li] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sarx_deser.sv
// Serial-to-parallel shifter with a slot bit counter.
// Finds rising edges of the synchronized bit clock and shifts data in.
// In right-justified mode it shifts on every edge, so only the newest
// WORD_W bits remain. In I2S mode it shifts only slot bit indices 1..WORD_W.
// The counter restarts on each word-select edge and saturates one bit past
// the word. Assumes that no bit-clock rise falls in the same cycle as a
// word-select edge.
module sarx_deser #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_i2s,
    input  logic              bclk_s,
    input  logic              sdata_s,
    input  logic              ws_edge,
    output logic [WORD_W-1:0] word_o,
    output logic              slot_full_o
);

    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W);

    logic             bclk_d;
    logic             bit_rise;
    logic             in_window;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] shreg;

    assign bit_rise  = bclk_s & ~bclk_d;
    assign in_window = fmt_i2s ? ((cnt != '0) && (cnt <= LAST_IDX)) : 1'b1;

    // Remember the previous bit-clock level for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk_s;
    end

    // Count bit-clock rises since the last word-select edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt <= '0;
        else if (ws_edge)                     cnt <= '0;
        else if (bit_rise && cnt != CNT_TOP)  cnt <= cnt + 1'b1;
    end

    // Shift one data bit in on each rise inside the capture window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (bit_rise && !ws_edge && in_window)
            shreg <= {shreg[WORD_W-2:0], sdata_s};
    end

    assign word_o      = shreg;
    assign slot_full_o = (cnt >= (fmt_i2s ? CNT_TOP : LAST_IDX));

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_TOP)
        else $error("slot counter beyond saturation");

endmodule

// File: rtl/sarx_slot_ctl.sv
// Slot controller.
// Detects word-select edges and decides what the closing slot produces:
// a left word, a right word, or an incomplete-frame event. The first edge
// after reset only primes the controller, because the slot before it has
// no known start.
module sarx_slot_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic fmt_i2s,
    input  logic ws_s,
    input  logic slot_full,
    output logic ws_edge,
    output logic close_left,
    output logic close_right,
    output logic close_err
);
    import sarx_pkg::*;

    logic       ws_d;
    logic       primed;
    sarx_chan_e chan;

    assign ws_edge = ws_s ^ ws_d;
    assign chan    = sarx_closing_chan(fmt_i2s, ws_s);

    // Hold the previous word-select level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ws_d <= 1'b0;
        else        ws_d <= ws_s;
    end

    // Become primed on the first word-select edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       primed <= 1'b0;
        else if (ws_edge) primed <= 1'b1;
    end

    assign close_left  = ws_edge & primed &  slot_full & (chan == CH_LEFT);
    assign close_right = ws_edge & primed &  slot_full & (chan == CH_RIGHT);
    assign close_err   = ws_edge & primed & ~slot_full;

    a_r8_primed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        primed |=> primed)
        else $error("primed flag dropped outside reset");

endmodule

// File: rtl/serial_audio_rx.sv
// Dual-format serial audio receiver, top level.
// Synchronizes the three serial lines, deserializes words in right-justified
// or I2S framing, and places each closed slot in its channel register with a
// one-cycle strobe. A slot that closes short pulses frame_err instead.
// Assumes that fmt_i2s changes only during reset, and that each half period
// of the bit clock lasts at least SYNC_STAGES + 1 clk periods.
module serial_audio_rx #(
    parameter int WORD_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_in,
    input  logic              wsel_in,
    input  logic              sdata_in,
    input  logic              fmt_i2s,
    output logic [WORD_W-1:0] left_word,
    output logic              left_valid,
    output logic [WORD_W-1:0] right_word,
    output logic              right_valid,
    output logic              frame_err
);
    import sarx_pkg::*;

    logic [SARX_NUM_LINES-1:0] raw_lines;
    logic [SARX_NUM_LINES-1:0] sync_lines;
    logic [WORD_W-1:0]         shift_word;
    logic                      slot_full;
    logic                      ws_edge;
    logic                      close_left;
    logic                      close_right;
    logic                      close_err;
    logic [SARX_NUM_CH-1:0]    take;
    logic [WORD_W-1:0]         word_q  [SARX_NUM_CH];
    logic [SARX_NUM_CH-1:0]    valid_q;
    logic                      err_q;

    assign raw_lines[SARX_LINE_BCLK] = bclk_in;
    assign raw_lines[SARX_LINE_WS]   = wsel_in;
    assign raw_lines[SARX_LINE_DATA] = sdata_in;

    sarx_sync #(
        .WIDTH  (SARX_NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_lines),
        .sync_o  (sync_lines)
    );

    sarx_deser #(
        .WORD_W (WORD_W)
    ) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_i2s     (fmt_i2s),
        .bclk_s      (sync_lines[SARX_LINE_BCLK]),
        .sdata_s     (sync_lines[SARX_LINE_DATA]),
        .ws_edge     (ws_edge),
        .word_o      (shift_word),
        .slot_full_o (slot_full)
    );

    sarx_slot_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_i2s     (fmt_i2s),
        .ws_s        (sync_lines[SARX_LINE_WS]),
        .slot_full   (slot_full),
        .ws_edge     (ws_edge),
        .close_left  (close_left),
        .close_right (close_right),
        .close_err   (close_err)
    );

    assign take[CH_LEFT]  = close_left;
    assign take[CH_RIGHT] = close_right;

    generate
        for (genvar ch = 0; ch < SARX_NUM_CH; ch++) begin : g_chan
            // Load the finished word into this channel register and strobe it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q[ch]  <= '0;
                    valid_q[ch] <= 1'b0;
                end else begin
                    valid_q[ch] <= take[ch];
                    if (take[ch]) word_q[ch] <= shift_word;
                end
            end
        end
    endgenerate

    // Register the incomplete-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= close_err;
    end

    assign left_word   = word_q[CH_LEFT];
    assign right_word  = word_q[CH_RIGHT];
    assign left_valid  = valid_q[CH_LEFT];
    assign right_valid = valid_q[CH_RIGHT];
    assign frame_err   = err_q;

    a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({left_valid, right_valid, frame_err}))
        else $error("more than one output event in a cycle");

    a_r5_left_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        left_valid |=> !left_valid)
        else $error("left strobe longer than one cycle");

    a_r5_right_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid |=> !right_valid)
        else $error("right strobe longer than one cycle");

    a_r6_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !left_valid |-> $stable(left_word))
        else $error("left word changed without strobe");

    a_r6_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !right_valid |-> $stable(right_word))
        else $error("right word changed without strobe");

    a_r7_err_keeps_words: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> ($stable(left_word) && $stable(right_word)))
        else $error("word changed after incomplete frame");

endmodule

// File: tb/serial_audio_rx_tb.sv
// Scoreboard bench: the slot driver queues the result each slot must produce,
// and a monitor at the falling clk edge pops and compares each output event.
module serial_audio_rx_tb;

    typedef struct {
        int          kind;   // 0 left, 1 right, 2 frame error
        logic [17:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b1;
    logic        wsel = 1'b0;
    logic        sdata = 1'b0;
    logic        fmt = 1'b0;
    logic [17:0] left_word, right_word;
    logic        left_valid, right_valid, frame_err;

    exp_t        exp_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    serial_audio_rx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_in     (bclk),
        .wsel_in     (wsel),
        .sdata_in    (sdata),
        .fmt_i2s     (fmt),
        .left_word   (left_word),
        .left_valid  (left_valid),
        .right_word  (right_word),
        .right_valid (right_valid),
        .frame_err   (frame_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: each output event must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && (left_valid || right_valid || frame_err)) begin
            check("R10 single event", 32'($countones({left_valid, right_valid, frame_err})), 32'd1);
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R8 unexpected event: actual=%b%b%b expected=none",
                         left_valid, right_valid, frame_err);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                case (e.kind)
                    0: begin
                        check({e.tag, " left strobe"}, 32'(left_valid), 32'd1);
                        check({e.tag, " left word"}, 32'(left_word), 32'(e.data));
                    end
                    1: begin
                        check({e.tag, " right strobe"}, 32'(right_valid), 32'd1);
                        check({e.tag, " right word"}, 32'(right_word), 32'(e.data));
                    end
                    default: check({e.tag, " frame_err"}, 32'(frame_err), 32'd1);
                endcase
            end
        end
    end

    // One bit period: 50 ns low, 50 ns high; optional data glitch in the high phase.
    task automatic send_bit(input logic b, input logic glitch);
        bclk = 1'b0; sdata = b;
        repeat (5) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
        if (glitch) sdata = ~b;
        repeat (3) @(negedge clk);
    endtask

    // Right-justified slot: pad bits, then the low nbits of w, MSB first.
    task automatic rj_slot(input logic ws, input logic [17:0] w, input int pad,
                           input int nbits, input logic glitch, input string tag);
        exp_t e;
        e.data = w; e.tag = tag;
        e.kind = (nbits >= 18) ? (ws ? 0 : 1) : 2;
        exp_q.push_back(e);
        wsel = ws;
        for (int i = 0; i < pad; i++) send_bit(1'b1, 1'b0);
        for (int i = nbits - 1; i >= 0; i--) send_bit(w[i], glitch);
    endtask

    // I2S slot of len bits: delay bit, word MSB first, then padding ones.
    task automatic i2s_slot(input logic ws, input logic [17:0] w, input int len, input string tag);
        exp_t e;
        e.data = w; e.tag = tag;
        e.kind = (len >= 19) ? (ws ? 1 : 0) : 2;
        exp_q.push_back(e);
        wsel = ws;
        send_bit(~w[0], 1'b0);
        for (int k = 0; k < len - 1; k++) send_bit((k < 18) ? w[17-k] : 1'b1, 1'b0);
    endtask

    task automatic close_and_drain(input logic ws);
        wsel = ws;
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
        repeat (20) @(negedge clk);
        check("R5 all expected events seen", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic do_reset(input logic f);
        rst_n = 1'b0; fmt = f; wsel = 1'b0; bclk = 1'b1; sdata = 1'b0;
        repeat (8) @(negedge clk);
        check("R1 left_word in reset", 32'(left_word), 32'd0);
        check("R1 strobes in reset", 32'({left_valid, right_valid, frame_err}), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 right_word after reset", 32'(right_word), 32'd0);
        check("R1 strobes after reset", 32'({left_valid, right_valid, frame_err}), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R5 watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Right-justified mode; the first edge only primes (R8).
        do_reset(1'b0);
        rj_slot(1'b1, 18'h2ABCD, 0, 18, 1'b0, "R2 R8 rj left");
        rj_slot(1'b0, 18'h12345, 0, 18, 1'b0, "R2 rj right");
        rj_slot(1'b1, 18'h3FFFF, 6, 18, 1'b0, "R3 rj left padded");
        rj_slot(1'b0, 18'h20000, 14, 18, 1'b0, "R3 rj right padded");
        rj_slot(1'b1, 18'h00001, 0, 17, 1'b0, "R7 rj 17-bit slot");
        rj_slot(1'b0, 18'h15555, 0, 18, 1'b1, "R9 rj glitched right");
        check("R7 left_word held after error", 32'(left_word), 32'h3FFFF);
        check("R6 right_word held inside slot", 32'(right_word), 32'h20000);
        rj_slot(1'b1, 18'h0AAAA, 0, 18, 1'b0, "R2 rj left");
        close_and_drain(1'b0);

        // I2S mode.
        do_reset(1'b1);
        i2s_slot(1'b1, 18'h00000, 20, "R4 R8 i2s right");
        i2s_slot(1'b0, 18'h2468A, 32, "R4 i2s left trailing");
        i2s_slot(1'b1, 18'h3C3C3, 19, "R4 i2s right 19-bit");
        i2s_slot(1'b0, 18'h11111, 18, "R7 i2s 18-bit slot");
        i2s_slot(1'b1, 18'h1FFFF, 24, "R4 i2s right");
        check("R7 left_word held after i2s error", 32'(left_word), 32'h2468A);
        i2s_slot(1'b0, 18'h20001, 19, "R4 i2s left negative");
        close_and_drain(1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule